// File: doc/BRIEF.md
# Auto-MDIX Link Resolution Sequencer

This block brings up a twisted-pair port whose transceiver has no automatic pair swap of its own. After a start pulse it drives a crossover-select output low (straight wiring) and then polls the PHY's basic status register (register 1) through a one-request-at-a-time management read interface. Before each poll it waits a programmable retry delay. Every poll that finds no link flips the select output between straight and crossed wiring. The block gives up after a fixed retry budget.

Once a poll sees the link up, the block reads register 1 a second time. If that read shows that negotiation or parallel detection has finished, the block reads the vendor status register 31 to get speed and duplex. It then runs a chain of conditional reads to decide pause support. At the end it publishes a four-bit port-status word and pulses `done`. If the retries run out, it raises a failure flag and leaves the status word as it was.

The management serial protocol is outside this block. The block presents a register number with a one-cycle request strobe and waits for a completion strobe that carries the read data.

Top module: `mdix_link_seq`

## Requirements
- R1: On a start pulse accepted while idle, `xoverSel` goes low and the first read of register 1 is requested RETRY_DELAY+2 cycles after the cycle in which `start` was high.
- R2: A poll response with bit 2 clear flips `xoverSel` and the next poll is requested RETRY_DELAY+2 cycles after the completion cycle. A poll response with bit 2 set ends polling.
- R3: The retry budget is counted down before each poll, so at most RETRY_BUDGET-1 polls are made. When the budget runs out, `linkFail` goes high, `done` pulses and `portStatus` keeps its previous value.
- R4: After the link is seen, register 1 is read again. If bit 5 of that read is clear, no further reads are made and the status shows link only.
- R5: Speed and duplex come from bits 4:2 of register 31. Code 1 gives 10 Mb/s half duplex, 5 gives 10 Mb/s full duplex, 2 gives 100 Mb/s half duplex and 6 gives 100 Mb/s full duplex. Any other code leaves both bits clear.
- R6: Pause is set only when all of the following hold, tested in this order, each by its own read: register 1 bit 3 (from the confirm read), then register 6 bit 0, then register 4 bit 10, then register 5 bit 10. The chain stops at the first clear bit.
- R7: At most one read is outstanding. Each follow-on read after link-up is requested in the cycle after the previous completion.
- R8: `portStatus` holds link in bit 0, 100 Mb/s in bit 1, full duplex in bit 2 and pause in bit 3.
- R9: On success, `portStatus` updates and `done` pulses for one cycle, two cycles after the final completion.
- R10: A start pulse while the block is busy is ignored.
- R11: After reset, `portStatus`, `xoverSel`, `busy`, `done`, `linkFail` and the request strobe are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a link resolution run (ignored while busy) |
| xoverSel | output | 1 | Pair-swap select: 0 straight, 1 crossed |
| mgmtReqValid | output | 1 | One-cycle management read request |
| mgmtReqReg | output | 5 | PHY register number of the request |
| mgmtRspDone | input | 1 | One-cycle completion of the outstanding read |
| mgmtRspData | input | 16 | Read data, valid with `mgmtRspDone` |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| linkFail | output | 1 | Last run exhausted its retries |
| portStatus | output | 4 | {pause, full duplex, 100 Mb/s, link} |

## Verification
The first poll is due RETRY_DELAY+2 cycles after the start cycle. Every poll after a failed one is due RETRY_DELAY+2 cycles after that poll's completion. Each follow-on read is due one cycle after its predecessor completes. `done` with the new status is due two cycles after the last completion on success and three cycles after it on failure. The bench's PHY model timestamps every request and completion with a cycle counter sampled on the falling edge, compares each timestamp against these offsets, and records the select level at every poll. It also counts any request raised while one is still pending.

// File: rtl/mdix_pkg.sv
package mdix_pkg;

  localparam logic [4:0] REG_BSR    = 5'd1;
  localparam logic [4:0] REG_ADV    = 5'd4;
  localparam logic [4:0] REG_LPADV  = 5'd5;
  localparam logic [4:0] REG_ANEXP  = 5'd6;
  localparam logic [4:0] REG_VSTAT  = 5'd31;

  localparam int BIT_LINK     = 2;
  localparam int BIT_NEGDONE  = 5;
  localparam int BIT_ANABLE   = 3;
  localparam int BIT_CODE_LO  = 2;
  localparam int BIT_LPAN     = 0;
  localparam int BIT_PAUSE    = 10;

  localparam int STAT_LINK  = 0;
  localparam int STAT_FAST  = 1;
  localparam int STAT_FULL  = 2;
  localparam int STAT_PAUSE = 3;
  localparam int STAT_W     = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_DEC, S_DELAY, S_REQ, S_WAIT, S_FAIL, S_FINISH
  } seqState_t;

  typedef enum logic [2:0] {
    PH_POLL, PH_CONFIRM, PH_VSTAT, PH_ANEXP, PH_ADV, PH_LPADV
  } readPhase_t;

  typedef struct packed {
    logic arm;
    logic decRetry;
    logic loadDelay;
    logic tickDelay;
    logic toggleSel;
    logic capConfirm;
    logic capSpeed;
    logic setPause;
    logic publish;
    logic markFail;
  } seqStrobe_t;

  typedef struct packed {
    logic       linkUp;
    logic       negDone;
    logic       anAble;
    logic [2:0] spdCode;
    logic       partnerAn;
    logic       pauseBit;
  } rspFields_t;

  // returns {fullDuplex, fast}
  function automatic logic [1:0] decodeMode(input logic [2:0] code);
    case (code)
      3'd1:    decodeMode = 2'b00;
      3'd5:    decodeMode = 2'b10;
      3'd2:    decodeMode = 2'b01;
      3'd6:    decodeMode = 2'b11;
      default: decodeMode = 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/mdix_datapath.sv
module mdix_datapath
  import mdix_pkg::*;
#(
  parameter int unsigned RETRY_DELAY  = 500_000_000,
  parameter int unsigned RETRY_BUDGET = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  rspFields_t        rsp,
  output logic              retryLast,
  output logic              delayZero,
  output logic              anAble,
  output logic              xoverSel,
  output logic              done,
  output logic              linkFail,
  output logic [STAT_W-1:0] portStatus
);

  localparam int RET_W = $clog2(RETRY_BUDGET + 1);
  localparam int DLY_W = $clog2(RETRY_DELAY + 1);
  localparam logic [RET_W-1:0] RET_INIT = RET_W'(RETRY_BUDGET);
  localparam logic [DLY_W-1:0] DLY_INIT = DLY_W'(RETRY_DELAY - 1);

  logic [RET_W-1:0] retryCnt;
  logic [DLY_W-1:0] delayCnt;
  logic             fastPend;
  logic             fullPend;
  logic             pausePend;
  logic [1:0]       mode;

  assign retryLast = (retryCnt <= RET_W'(1));
  assign delayZero = (delayCnt == '0);
  assign mode      = decodeMode(rsp.spdCode);

  // retry budget and inter-poll wait
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      retryCnt <= '0;
      delayCnt <= '0;
    end else begin
      if (stb.arm)            retryCnt <= RET_INIT;
      else if (stb.decRetry)  retryCnt <= retryCnt - RET_W'(1);
      if (stb.loadDelay)      delayCnt <= DLY_INIT;
      else if (stb.tickDelay) delayCnt <= delayCnt - DLY_W'(1);
    end
  end

  // wiring select
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              xoverSel <= 1'b0;
    else if (stb.arm)       xoverSel <= 1'b0;
    else if (stb.toggleSel) xoverSel <= ~xoverSel;
  end

  // results gathered during the resolution chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      anAble    <= 1'b0;
      fastPend  <= 1'b0;
      fullPend  <= 1'b0;
      pausePend <= 1'b0;
    end else if (stb.arm) begin
      anAble    <= 1'b0;
      fastPend  <= 1'b0;
      fullPend  <= 1'b0;
      pausePend <= 1'b0;
    end else begin
      if (stb.capConfirm) anAble <= rsp.anAble;
      if (stb.capSpeed) begin
        fastPend <= mode[0];
        fullPend <= mode[1];
      end
      if (stb.setPause) pausePend <= 1'b1;
    end
  end

  // published outcome
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      portStatus <= '0;
      done       <= 1'b0;
      linkFail   <= 1'b0;
    end else begin
      done <= stb.publish | stb.markFail;
      if (stb.publish) begin
        portStatus[STAT_LINK]  <= 1'b1;
        portStatus[STAT_FAST]  <= fastPend;
        portStatus[STAT_FULL]  <= fullPend;
        portStatus[STAT_PAUSE] <= pausePend;
      end
      if (stb.arm)           linkFail <= 1'b0;
      else if (stb.markFail) linkFail <= 1'b1;
    end
  end

endmodule

// File: rtl/mdix_control.sv
module mdix_control
  import mdix_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       rspDone,
  input  rspFields_t rsp,
  input  logic       retryLast,
  input  logic       delayZero,
  input  logic       anAble,
  output seqStrobe_t stb,
  output logic       reqValid,
  output logic [4:0] reqReg,
  output logic       busy
);

  seqState_t  state, stateNext;
  readPhase_t phase, phaseNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      phase <= PH_POLL;
    end else begin
      state <= stateNext;
      phase <= phaseNext;
    end
  end

  always_comb begin
    case (phase)
      PH_POLL, PH_CONFIRM: reqReg = REG_BSR;
      PH_VSTAT:            reqReg = REG_VSTAT;
      PH_ANEXP:            reqReg = REG_ANEXP;
      PH_ADV:              reqReg = REG_ADV;
      PH_LPADV:            reqReg = REG_LPADV;
      default:             reqReg = REG_BSR;
    endcase
  end

  assign reqValid = (state == S_REQ);
  assign busy     = (state != S_IDLE);

  always_comb begin
    stateNext = state;
    phaseNext = phase;
    stb       = '0;
    case (state)
      S_IDLE: begin
        if (start) begin
          stb.arm   = 1'b1;
          phaseNext = PH_POLL;
          stateNext = S_DEC;
        end
      end
      S_DEC: begin
        stb.decRetry = 1'b1;
        if (retryLast) begin
          stateNext = S_FAIL;
        end else begin
          stb.loadDelay = 1'b1;
          stateNext     = S_DELAY;
        end
      end
      S_DELAY: begin
        if (delayZero) stateNext = S_REQ;
        else           stb.tickDelay = 1'b1;
      end
      S_REQ: stateNext = S_WAIT;
      S_WAIT: begin
        if (rspDone) begin
          stateNext = S_FINISH;
          case (phase)
            PH_POLL: begin
              if (rsp.linkUp) begin
                phaseNext = PH_CONFIRM;
                stateNext = S_REQ;
              end else begin
                stb.toggleSel = 1'b1;
                stateNext     = S_DEC;
              end
            end
            PH_CONFIRM: begin
              stb.capConfirm = 1'b1;
              if (rsp.negDone) begin
                phaseNext = PH_VSTAT;
                stateNext = S_REQ;
              end
            end
            PH_VSTAT: begin
              stb.capSpeed = 1'b1;
              if (anAble) begin
                phaseNext = PH_ANEXP;
                stateNext = S_REQ;
              end
            end
            PH_ANEXP: begin
              if (rsp.partnerAn) begin
                phaseNext = PH_ADV;
                stateNext = S_REQ;
              end
            end
            PH_ADV: begin
              if (rsp.pauseBit) begin
                phaseNext = PH_LPADV;
                stateNext = S_REQ;
              end
            end
            PH_LPADV: stb.setPause = rsp.pauseBit;
            default:  stateNext = S_FINISH;
          endcase
        end
      end
      S_FAIL: begin
        stb.markFail = 1'b1;
        stateNext    = S_IDLE;
      end
      S_FINISH: begin
        stb.publish = 1'b1;
        stateNext   = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

endmodule

// File: rtl/mdix_link_seq.sv
module mdix_link_seq
  import mdix_pkg::*;
#(
  parameter int unsigned RETRY_DELAY  = 500_000_000,
  parameter int unsigned RETRY_BUDGET = 100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output logic        xoverSel,
  output logic        mgmtReqValid,
  output logic [4:0]  mgmtReqReg,
  input  logic        mgmtRspDone,
  input  logic [15:0] mgmtRspData,
  output logic        busy,
  output logic        done,
  output logic        linkFail,
  output logic [3:0]  portStatus
);

  seqStrobe_t stb;
  rspFields_t rsp;
  logic       retryLast;
  logic       delayZero;
  logic       anAble;
  logic       unusedRspBits;

  assign rsp.linkUp    = mgmtRspData[BIT_LINK];
  assign rsp.negDone   = mgmtRspData[BIT_NEGDONE];
  assign rsp.anAble    = mgmtRspData[BIT_ANABLE];
  assign rsp.spdCode   = mgmtRspData[BIT_CODE_LO +: 3];
  assign rsp.partnerAn = mgmtRspData[BIT_LPAN];
  assign rsp.pauseBit  = mgmtRspData[BIT_PAUSE];
  assign unusedRspBits = &{1'b0, mgmtRspData};

  mdix_control i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .rspDone   (mgmtRspDone),
    .rsp       (rsp),
    .retryLast (retryLast),
    .delayZero (delayZero),
    .anAble    (anAble),
    .stb       (stb),
    .reqValid  (mgmtReqValid),
    .reqReg    (mgmtReqReg),
    .busy      (busy)
  );

  mdix_datapath #(
    .RETRY_DELAY  (RETRY_DELAY),
    .RETRY_BUDGET (RETRY_BUDGET)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .rsp        (rsp),
    .retryLast  (retryLast),
    .delayZero  (delayZero),
    .anAble     (anAble),
    .xoverSel   (xoverSel),
    .done       (done),
    .linkFail   (linkFail),
    .portStatus (portStatus)
  );

endmodule

// File: rtl/mdix_link_seq_chk.sv
module mdix_link_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       xoverSel,
  input logic       mgmtReqValid,
  input logic [4:0] mgmtReqReg,
  input logic       mgmtRspDone,
  input logic       busy,
  input logic       done,
  input logic       linkFail,
  input logic [3:0] portStatus
);

  logic pending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             pending <= 1'b0;
    else if (mgmtReqValid) pending <= 1'b1;
    else if (mgmtRspDone)  pending <= 1'b0;
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    mgmtReqValid |-> !pending); // R7

  AST_REQ_REG_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    mgmtReqValid |-> (mgmtReqReg == 5'd1 || mgmtReqReg == 5'd4 || mgmtReqReg == 5'd5 ||
                      mgmtReqReg == 5'd6 || mgmtReqReg == 5'd31)); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_FAIL_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(linkFail) |-> $stable(portStatus)); // R3

  AST_SUCCESS_HAS_LINK: assert property (@(posedge clk) disable iff (!rstN)
    (done && !linkFail) |-> portStatus[0]); // R8

  AST_SELECT_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(xoverSel)); // R2

  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mgmtReqValid); // R10

  AST_START_CLEARS_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> !xoverSel); // R1

endmodule

bind mdix_link_seq mdix_link_seq_chk i_chk (
  .clk          (clk),
  .rstN         (rstN),
  .start        (start),
  .xoverSel     (xoverSel),
  .mgmtReqValid (mgmtReqValid),
  .mgmtReqReg   (mgmtReqReg),
  .mgmtRspDone  (mgmtRspDone),
  .busy         (busy),
  .done         (done),
  .linkFail     (linkFail),
  .portStatus   (portStatus)
);

// File: tb/test_mdix_link_seq.sv
`timescale 1ns/1ps
module test_mdix_link_seq;

  localparam int D = 5;
  localparam int B = 6;
  localparam int MAXPOLL = B - 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        xoverSel, mgmtReqValid, busy, done, linkFail;
  logic [4:0]  mgmtReqReg;
  logic        mgmtRspDone = 1'b0;
  logic [15:0] mgmtRspData = '0;
  logic [3:0]  portStatus;

  always #2 clk = ~clk;

  mdix_link_seq #(.RETRY_DELAY(D), .RETRY_BUDGET(B)) i_mdix_link_seq (
    .clk(clk), .rstN(rstN), .start(start), .xoverSel(xoverSel),
    .mgmtReqValid(mgmtReqValid), .mgmtReqReg(mgmtReqReg),
    .mgmtRspDone(mgmtRspDone), .mgmtRspData(mgmtRspData),
    .busy(busy), .done(done), .linkFail(linkFail), .portStatus(portStatus)
  );

  int tests = 0, fails = 0;
  bit finished = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // PHY model configuration
  int cfgLinkPoll;
  bit cfgNegDone, cfgAnAble, cfgLpAn, cfgAdvPause, cfgLpPause;
  int cfgCode;

  // PHY model observations
  int seqReg[0:31];
  int seqLen, pollIdx, waitLeft, curReg, lastRspCyc, startCyc;
  bit linkSeen, prevFailedPoll, firstReq, curIsPoll;
  int firstErr, pollGapErr, xoverErr, chainErr, overlapErr;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] answer(input int reg_, input bit isPoll, input bit link);
    logic [15:0] v;
    v = 16'($urandom);
    if (reg_ == 1 && isPoll) begin
      v[2] = link;
    end else if (reg_ == 1) begin
      v[2] = 1'b1; v[5] = cfgNegDone; v[3] = cfgAnAble;
    end else if (reg_ == 31) begin
      v[4:2] = 3'(cfgCode);
    end else if (reg_ == 6) begin
      v[0] = cfgLpAn;
    end else if (reg_ == 4) begin
      v[10] = cfgAdvPause;
    end else if (reg_ == 5) begin
      v[10] = cfgLpPause;
    end
    return v;
  endfunction

  function automatic int expStatus();
    int s;
    s = 1;
    if (cfgNegDone) begin
      case (cfgCode)
        5: s |= 4;
        2: s |= 2;
        6: s |= 6;
        default: ;
      endcase
      if (cfgAnAble && cfgLpAn && cfgAdvPause && cfgLpPause) s |= 8;
    end
    return s;
  endfunction

  // PHY model: answers each request after a random latency
  initial begin
    forever begin
      int expCyc;
      @(negedge clk);
      mgmtRspDone = 1'b0;
      if (waitLeft > 0) begin
        if (mgmtReqValid) overlapErr++;
        waitLeft--;
        if (waitLeft == 0) begin
          mgmtRspDone = 1'b1;
          if (curIsPoll) begin
            bit lk;
            lk = (pollIdx == cfgLinkPoll);
            mgmtRspData = answer(curReg, 1'b1, lk);
            linkSeen = lk;
            prevFailedPoll = !lk;
            pollIdx++;
          end else begin
            mgmtRspData = answer(curReg, 1'b0, 1'b0);
            prevFailedPoll = 1'b0;
          end
          lastRspCyc = cyc;
        end
      end else if (mgmtReqValid) begin
        curReg = int'(mgmtReqReg);
        curIsPoll = !linkSeen;
        if (seqLen < 32) seqReg[seqLen] = curReg;
        seqLen++;
        if (firstReq) begin
          expCyc = startCyc + D + 2;
          if (cyc != expCyc) firstErr++;
        end else if (prevFailedPoll) begin
          expCyc = lastRspCyc + D + 2;
          if (cyc != expCyc) pollGapErr++;
        end else begin
          expCyc = lastRspCyc + 1;
          if (cyc != expCyc) chainErr++;
        end
        if (curIsPoll && (xoverSel != 1'(pollIdx % 2))) xoverErr++;
        firstReq = 1'b0;
        waitLeft = 1 + int'($urandom % 4);
      end
    end
  end

  int prevStatus = 0;

  task automatic runCase(input int linkPoll, input bit negDone, input bit anAble,
                         input int code, input bit lpAn, input bit advP, input bit lpP,
                         input bit restartMid);
    int expSeq[0:31];
    int expLen, nPoll, doneCyc, guard, expSt;
    bit expFail;
    cfgLinkPoll = linkPoll; cfgNegDone = negDone; cfgAnAble = anAble; cfgCode = code;
    cfgLpAn = lpAn; cfgAdvPause = advP; cfgLpPause = lpP;
    seqLen = 0; pollIdx = 0; waitLeft = 0; linkSeen = 0; prevFailedPoll = 0; firstReq = 1;
    firstErr = 0; pollGapErr = 0; xoverErr = 0; chainErr = 0; overlapErr = 0;
    @(negedge clk);
    start = 1'b1; startCyc = cyc;
    @(negedge clk);
    start = 1'b0;
    if (restartMid) begin
      repeat (2) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (!done && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    doneCyc = cyc;
    expFail = (linkPoll >= MAXPOLL);
    nPoll = expFail ? MAXPOLL : linkPoll + 1;
    expLen = 0;
    for (int i = 0; i < nPoll; i++) expSeq[expLen++] = 1;
    if (!expFail) begin
      expSeq[expLen++] = 1;
      if (negDone) begin
        expSeq[expLen++] = 31;
        if (anAble) begin
          expSeq[expLen++] = 6;
          if (lpAn) begin
            expSeq[expLen++] = 4;
            if (advP) expSeq[expLen++] = 5;
          end
        end
      end
    end
    chk(done == 1'b1, "R9 done seen", int'(done), 1);
    chk(firstErr == 0, restartMid ? "R10 first poll timing after ignored restart" : "R1 first poll timing", firstErr, 0);
    chk(pollGapErr == 0, "R2 poll spacing", pollGapErr, 0);
    chk(xoverErr == 0, "R2 select level at polls", xoverErr, 0);
    chk(chainErr == 0 && overlapErr == 0, "R7 chain spacing/outstanding", chainErr + overlapErr, 0);
    chk(seqLen == expLen, negDone ? "R6 read count" : "R4 read count", seqLen, expLen);
    for (int i = 0; i < expLen && i < seqLen; i++)
      chk(seqReg[i] == expSeq[i], "R6 read order", seqReg[i], expSeq[i]);
    chk(linkFail == expFail, "R3 fail flag", int'(linkFail), int'(expFail));
    if (expFail) begin
      chk(int'(portStatus) == prevStatus, "R3 status unchanged", int'(portStatus), prevStatus);
      chk(doneCyc == lastRspCyc + 3, "R3 done timing", doneCyc - lastRspCyc, 3);
      chk(xoverSel == 1'(MAXPOLL % 2), "R2 final select", int'(xoverSel), MAXPOLL % 2);
    end else begin
      expSt = expStatus();
      chk(portStatus[0] == 1'b1, "R8 link bit", int'(portStatus[0]), 1);
      chk(portStatus[2:1] == 2'(expSt >> 1), "R5 speed/duplex", int'(portStatus[2:1]), (expSt >> 1) & 3);
      chk(portStatus[3] == 1'(expSt >> 3), "R6 pause", int'(portStatus[3]), (expSt >> 3) & 1);
      chk(doneCyc == lastRspCyc + 2, "R9 done timing", doneCyc - lastRspCyc, 2);
      chk(xoverSel == 1'(linkPoll % 2), "R2 final select", int'(xoverSel), linkPoll % 2);
      prevStatus = expSt;
    end
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", int'(done), 0);
    chk(busy == 1'b0, "R9 idle after done", int'(busy), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(portStatus == 4'd0, "R11 reset status", int'(portStatus), 0);
    chk(xoverSel == 1'b0, "R11 reset select", int'(xoverSel), 0);
    chk(busy == 1'b0 && done == 1'b0 && linkFail == 1'b0 && mgmtReqValid == 1'b0,
        "R11 reset controls", int'({busy, done, linkFail, mgmtReqValid}), 0);
    rstN = 1'b1;
    @(negedge clk);
    runCase(0, 1, 1, 6, 1, 1, 1, 0);
    runCase(5, 1, 1, 6, 1, 1, 1, 0);
    runCase(2, 1, 1, 1, 1, 1, 0, 0);
    runCase(4, 1, 0, 5, 1, 1, 1, 0);
    runCase(9, 0, 0, 0, 0, 0, 0, 0);
    runCase(1, 0, 1, 6, 1, 1, 1, 0);
    runCase(3, 1, 1, 2, 0, 1, 1, 0);
    runCase(0, 1, 1, 3, 1, 0, 1, 0);
    runCase(1, 1, 1, 7, 1, 1, 1, 0);
    runCase(2, 1, 1, 0, 1, 1, 1, 0);
    runCase(3, 1, 1, 5, 1, 1, 1, 1);
    for (int n = 0; n < 20; n++)
      runCase(int'($urandom % 7), 1'($urandom), 1'($urandom), int'($urandom % 8),
              1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom % 4 == 0));
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule